// File: doc/BRIEF.md
# Pass-Voltage Tuning Controller

This block sits in a flash controller and searches, for one erase block at a time, for the lowest pass-through voltage code that the ECC can still tolerate. A lower pass voltage slows the slow build-up of errors in unread pages. The cost is extra read errors, and these must fit inside the spare correction capability. A tuning pass starts on a trigger that carries a block index and the index of that block's worst-case page. The first read is at the nominal code and measures the spare margin. The controller then lowers the code in coarse steps until the error count overflows the ECC capability. After that it raises the code one LSB at a time until the errors fit again. The code it finds is written into a per-block table together with the worst-case page index.

The same controller handles host reads. A host read looks up the block's tuned code in the table and issues the read at that code. If the decoder then reports more errors than it can correct, the controller repeats the read once at the nominal code. All reads go to an external read engine through a valid/ready request and a valid-only response carrying the error count. Only one read is outstanding at any time.

Top module: `vpass_tuner`

## Requirements
- R1: After reset every table entry holds the nominal code (500) with page index 0, tune_busy is low and no read request is issued.
- R2: A trigger is accepted only while the controller is idle. tune_busy is high from the cycle after an accepted trigger until the cycle in which tune_done pulses. A trigger that arrives while the controller is busy has no effect on the table.
- R3: The first read of a pass uses the nominal code and the worst-case page supplied with the trigger. If that read reports more errors than the capability (40), the result is the nominal code and no further read is made.
- R4: In the coarse phase each read lowers the code by tune_step (a step of 0 counts as 1) and stops at the first read whose error count exceeds the capability.
- R5: In the fine phase the code is raised by 1 for each read until a read reports at most the capability. That code is the result, and it never exceeds nominal.
- R6: No read is ever requested below the floor code, which is 94% of nominal (470). If the errors still fit at the floor, the result is the floor.
- R7: At the end of a pass the result code and the page index are written to the block's table entry, and tune_done pulses for one cycle. The query port returns an entry one cycle after its address is applied.
- R8: A host read is issued at the block's tuned code. If it reports more errors than the capability and the tuned code is below nominal, the read is issued once more at the nominal code. The response then carries the second count with host_rsp_retried = 1.
- R9: A host read at the nominal code is never retried. Its response carries the first count with host_rsp_retried = 0.
- R10: At most one read is outstanding. A new request is not raised until the previous one has been answered, and a stalled request holds its code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| tune_start | input | 1 | Trigger for one tuning pass |
| tune_block | input | BLK_W | Block to tune |
| tune_page | input | PAGE_W | Worst-case page of that block |
| tune_step | input | CODE_W | Coarse step in LSBs |
| tune_busy | output | 1 | Pass in progress |
| tune_done | output | 1 | One-cycle pulse after the table write |
| host_req_valid | input | 1 | Host read request |
| host_req_ready | output | 1 | Host request accepted |
| host_block | input | BLK_W | Host read block |
| host_page | input | PAGE_W | Host read page |
| host_rsp_valid | output | 1 | Host read result valid |
| host_rsp_errs | output | ERR_W | Final error count |
| host_rsp_retried | output | 1 | Result came from the nominal retry |
| rd_req_valid | output | 1 | Read-engine request |
| rd_req_ready | input | 1 | Read engine accepts |
| rd_req_block | output | BLK_W | Request block |
| rd_req_page | output | PAGE_W | Request page |
| rd_req_code | output | CODE_W | Pass voltage code for the read |
| rd_rsp_valid | input | 1 | Error count valid |
| rd_rsp_errs | input | ERR_W | Bit errors found by ECC |
| qry_block | input | BLK_W | Table query address |
| qry_code | output | CODE_W | Stored code, one cycle later |
| qry_page | output | PAGE_W | Stored page, one cycle later |

## Verification
A wrong phase or code register shows up on rd_req_code at the very next request. It appears either as a step of the wrong size or direction, or as a code below the floor, and it is visible within one read round trip. A wrong comparison against the capability ends a pass early or late. This leaves the wrong result in the table, which the query port shows one cycle after the pass and a host read shows as its request code. A retry that is missing or made twice shows as a wrong number of requests and a wrong retried flag on the host response.

// File: rtl/vpass_pkg.sv
package vpass_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOOK,
        ST_REQ,
        ST_WAIT,
        ST_WRITE
    } ctl_state_e;

    typedef enum logic [2:0] {
        PH_NOM,
        PH_COARSE,
        PH_FINE,
        PH_HOST1,
        PH_HOST2
    } ctl_phase_e;

endpackage

// File: rtl/vpass_step.sv
module vpass_step #(
    parameter int CODE_W  = 9,
    parameter int NOMINAL = 500,
    parameter int FLOOR   = 470
) (
    input  logic [CODE_W-1:0] cur_code,
    input  logic [CODE_W-1:0] step,
    output logic [CODE_W-1:0] coarse_next,
    output logic [CODE_W-1:0] fine_next,
    output logic              at_floor,
    output logic              at_nominal
);
    localparam logic [CODE_W:0] FLOOR_X   = (CODE_W+1)'(FLOOR);
    localparam logic [CODE_W:0] NOMINAL_X = (CODE_W+1)'(NOMINAL);

    logic [CODE_W:0] step_x;
    logic [CODE_W:0] cur_x;
    logic [CODE_W:0] room;

    always_comb begin
        cur_x  = {1'b0, cur_code};
        step_x = (step == '0) ? (CODE_W+1)'(1) : {1'b0, step};
        room   = (cur_x > FLOOR_X) ? (cur_x - FLOOR_X) : '0;
        if (room <= step_x) begin
            coarse_next = FLOOR_X[CODE_W-1:0];
        end else begin
            coarse_next = cur_code - step_x[CODE_W-1:0];
        end
        if (cur_x >= NOMINAL_X) begin
            fine_next = NOMINAL_X[CODE_W-1:0];
        end else begin
            fine_next = cur_code + 1'b1;
        end
        at_floor   = (cur_x <= FLOOR_X);
        at_nominal = (cur_x >= NOMINAL_X);
    end
endmodule

// File: rtl/vpass_table.sv
module vpass_table #(
    parameter int DEPTH   = 64,
    parameter int ADDR_W  = 6,
    parameter int CODE_W  = 9,
    parameter int PAGE_W  = 8,
    parameter int NOMINAL = 500
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CODE_W-1:0] wr_code,
    input  logic [PAGE_W-1:0] wr_page,
    input  logic [ADDR_W-1:0] a_addr,
    output logic [CODE_W-1:0] a_code,
    output logic [PAGE_W-1:0] a_page,
    input  logic [ADDR_W-1:0] b_addr,
    output logic [CODE_W-1:0] b_code,
    output logic [PAGE_W-1:0] b_page
);
    logic [CODE_W-1:0] code_mem [DEPTH];
    logic [PAGE_W-1:0] page_mem [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                code_mem[i] <= CODE_W'(NOMINAL);
                page_mem[i] <= '0;
            end
        end else if (wr_en) begin
            code_mem[wr_addr] <= wr_code;
            page_mem[wr_addr] <= wr_page;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_code <= CODE_W'(NOMINAL);
            a_page <= '0;
            b_code <= CODE_W'(NOMINAL);
            b_page <= '0;
        end else begin
            a_code <= code_mem[a_addr];
            a_page <= page_mem[a_addr];
            b_code <= code_mem[b_addr];
            b_page <= page_mem[b_addr];
        end
    end
endmodule

// File: rtl/vpass_tuner.sv
module vpass_tuner #(
    parameter int NUM_BLOCKS = 64,
    parameter int PAGE_W     = 8,
    parameter int CODE_W     = 9,
    parameter int ERR_W      = 16,
    parameter int NOMINAL    = 500,
    parameter int ECC_CAP    = 40,
    parameter int FLOOR_PCT  = 94,
    localparam int BLK_W     = $clog2(NUM_BLOCKS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tune_start,
    input  logic [BLK_W-1:0]  tune_block,
    input  logic [PAGE_W-1:0] tune_page,
    input  logic [CODE_W-1:0] tune_step,
    output logic              tune_busy,
    output logic              tune_done,
    input  logic              host_req_valid,
    output logic              host_req_ready,
    input  logic [BLK_W-1:0]  host_block,
    input  logic [PAGE_W-1:0] host_page,
    output logic              host_rsp_valid,
    output logic [ERR_W-1:0]  host_rsp_errs,
    output logic              host_rsp_retried,
    output logic              rd_req_valid,
    input  logic              rd_req_ready,
    output logic [BLK_W-1:0]  rd_req_block,
    output logic [PAGE_W-1:0] rd_req_page,
    output logic [CODE_W-1:0] rd_req_code,
    input  logic              rd_rsp_valid,
    input  logic [ERR_W-1:0]  rd_rsp_errs,
    input  logic [BLK_W-1:0]  qry_block,
    output logic [CODE_W-1:0] qry_code,
    output logic [PAGE_W-1:0] qry_page
);
    import vpass_pkg::*;

    localparam int FLOOR = (NOMINAL * FLOOR_PCT) / 100;
    localparam logic [CODE_W-1:0] NOM_CODE = CODE_W'(NOMINAL);
    localparam logic [ERR_W-1:0]  CAP_ERRS = ERR_W'(ECC_CAP);

    typedef struct packed {
        ctl_state_e        st;
        ctl_phase_e        ph;
        logic              tuning;
        logic [CODE_W-1:0] code;
        logic [BLK_W-1:0]  blk;
        logic [PAGE_W-1:0] page;
        logic              done;
        logic              hrsp_valid;
        logic [ERR_W-1:0]  hrsp_errs;
        logic              hrsp_retried;
    } ctl_regs_t;

    ctl_regs_t r_q, r_d;

    logic [CODE_W-1:0] coarse_next;
    logic [CODE_W-1:0] fine_next;
    logic              at_floor;
    logic              at_nominal;
    logic              overflow;
    logic              tbl_we;
    logic [BLK_W-1:0]  tbl_a_addr;
    logic [CODE_W-1:0] tbl_a_code;
    logic [PAGE_W-1:0] tbl_a_page;

    vpass_step #(
        .CODE_W (CODE_W),
        .NOMINAL(NOMINAL),
        .FLOOR  (FLOOR)
    ) step_i (
        .cur_code   (r_q.code),
        .step       (tune_step),
        .coarse_next(coarse_next),
        .fine_next  (fine_next),
        .at_floor   (at_floor),
        .at_nominal (at_nominal)
    );

    vpass_table #(
        .DEPTH  (NUM_BLOCKS),
        .ADDR_W (BLK_W),
        .CODE_W (CODE_W),
        .PAGE_W (PAGE_W),
        .NOMINAL(NOMINAL)
    ) table_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (tbl_we),
        .wr_addr(r_q.blk),
        .wr_code(r_q.code),
        .wr_page(r_q.page),
        .a_addr (tbl_a_addr),
        .a_code (tbl_a_code),
        .a_page (tbl_a_page),
        .b_addr (qry_block),
        .b_code (qry_code),
        .b_page (qry_page)
    );

    assign overflow   = rd_rsp_errs > CAP_ERRS;
    assign tbl_we     = (r_q.st == ST_WRITE);
    assign tbl_a_addr = (r_q.st == ST_IDLE) ? host_block : r_q.blk;

    always_comb begin
        r_d              = r_q;
        r_d.done         = 1'b0;
        r_d.hrsp_valid   = 1'b0;
        host_req_ready   = (r_q.st == ST_IDLE) && !tune_start;

        unique case (r_q.st)
            ST_IDLE: begin
                if (tune_start) begin
                    r_d.blk    = tune_block;
                    r_d.page   = tune_page;
                    r_d.code   = NOM_CODE;
                    r_d.ph     = PH_NOM;
                    r_d.tuning = 1'b1;
                    r_d.st     = ST_REQ;
                end else if (host_req_valid) begin
                    r_d.blk  = host_block;
                    r_d.page = host_page;
                    r_d.st   = ST_LOOK;
                end
            end
            ST_LOOK: begin
                r_d.code = tbl_a_code;
                r_d.ph   = PH_HOST1;
                r_d.st   = ST_REQ;
            end
            ST_REQ: begin
                if (rd_req_ready) begin
                    r_d.st = ST_WAIT;
                end
            end
            ST_WAIT: begin
                if (rd_rsp_valid) begin
                    unique case (r_q.ph)
                        PH_NOM: begin
                            if (overflow) begin
                                r_d.st = ST_WRITE;
                            end else begin
                                r_d.code = coarse_next;
                                r_d.ph   = PH_COARSE;
                                r_d.st   = ST_REQ;
                            end
                        end
                        PH_COARSE: begin
                            if (overflow) begin
                                r_d.code = fine_next;
                                r_d.ph   = PH_FINE;
                                r_d.st   = ST_REQ;
                            end else if (at_floor) begin
                                r_d.st = ST_WRITE;
                            end else begin
                                r_d.code = coarse_next;
                                r_d.st   = ST_REQ;
                            end
                        end
                        PH_FINE: begin
                            if (!overflow || at_nominal) begin
                                r_d.st = ST_WRITE;
                            end else begin
                                r_d.code = fine_next;
                                r_d.st   = ST_REQ;
                            end
                        end
                        PH_HOST1: begin
                            if (overflow && !at_nominal) begin
                                r_d.code = NOM_CODE;
                                r_d.ph   = PH_HOST2;
                                r_d.st   = ST_REQ;
                            end else begin
                                r_d.hrsp_valid   = 1'b1;
                                r_d.hrsp_errs    = rd_rsp_errs;
                                r_d.hrsp_retried = 1'b0;
                                r_d.st           = ST_IDLE;
                            end
                        end
                        default: begin
                            r_d.hrsp_valid   = 1'b1;
                            r_d.hrsp_errs    = rd_rsp_errs;
                            r_d.hrsp_retried = 1'b1;
                            r_d.st           = ST_IDLE;
                        end
                    endcase
                end
            end
            default: begin
                r_d.done   = 1'b1;
                r_d.tuning = 1'b0;
                r_d.st     = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st           <= ST_IDLE;
            r_q.ph           <= PH_NOM;
            r_q.tuning       <= 1'b0;
            r_q.code         <= NOM_CODE;
            r_q.blk          <= '0;
            r_q.page         <= '0;
            r_q.done         <= 1'b0;
            r_q.hrsp_valid   <= 1'b0;
            r_q.hrsp_errs    <= '0;
            r_q.hrsp_retried <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign tune_busy        = r_q.tuning;
    assign tune_done        = r_q.done;
    assign host_rsp_valid   = r_q.hrsp_valid;
    assign host_rsp_errs    = r_q.hrsp_errs;
    assign host_rsp_retried = r_q.hrsp_retried;
    assign rd_req_valid     = (r_q.st == ST_REQ);
    assign rd_req_block     = r_q.blk;
    assign rd_req_page      = r_q.page;
    assign rd_req_code      = r_q.code;

    logic unused_tbl_page;
    assign unused_tbl_page = ^tbl_a_page;
endmodule

// File: rtl/vpass_tuner_chk.sv
module vpass_tuner_chk #(
    parameter int CODE_W    = 9,
    parameter int NOMINAL   = 500,
    parameter int FLOOR_PCT = 94
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tune_start,
    input logic              tune_busy,
    input logic              tune_done,
    input logic              rd_req_valid,
    input logic              rd_req_ready,
    input logic [CODE_W-1:0] rd_req_code,
    input logic              rd_rsp_valid
);
    localparam int FLOOR = (NOMINAL * FLOOR_PCT) / 100;

    logic outstanding;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            outstanding <= 1'b0;
        end else if (rd_req_valid && rd_req_ready) begin
            outstanding <= 1'b1;
        end else if (rd_rsp_valid) begin
            outstanding <= 1'b0;
        end
    end

    assert_code_window_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_valid |-> (int'(rd_req_code) >= FLOOR) && (int'(rd_req_code) <= NOMINAL));

    assert_single_outstanding_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_valid |-> !outstanding);

    assert_stall_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_valid && !rd_req_ready |=> rd_req_valid && $stable(rd_req_code));

    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        tune_done |=> !tune_done);

    assert_busy_ends_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tune_done |-> !tune_busy && $past(tune_busy));

    assert_busy_from_trigger_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tune_busy) |-> $past(tune_start));
endmodule

bind vpass_tuner vpass_tuner_chk #(
    .CODE_W   (CODE_W),
    .NOMINAL  (NOMINAL),
    .FLOOR_PCT(FLOOR_PCT)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .tune_start  (tune_start),
    .tune_busy   (tune_busy),
    .tune_done   (tune_done),
    .rd_req_valid(rd_req_valid),
    .rd_req_ready(rd_req_ready),
    .rd_req_code (rd_req_code),
    .rd_rsp_valid(rd_rsp_valid)
);

// File: tb/vpass_tuner_tb_top.sv
`timescale 1ns/1ps
module vpass_tuner_tb_top;
    localparam int BLK_W  = 6;
    localparam int PAGE_W = 8;
    localparam int CODE_W = 9;
    localparam int ERR_W  = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic              tune_start = 1'b0;
    logic [BLK_W-1:0]  tune_block = '0;
    logic [PAGE_W-1:0] tune_page = '0;
    logic [CODE_W-1:0] tune_step = '0;
    logic              tune_busy, tune_done;
    logic              host_req_valid = 1'b0;
    logic              host_req_ready;
    logic [BLK_W-1:0]  host_block = '0;
    logic [PAGE_W-1:0] host_page = '0;
    logic              host_rsp_valid, host_rsp_retried;
    logic [ERR_W-1:0]  host_rsp_errs;
    logic              rd_req_valid;
    logic              rd_req_ready;
    logic [BLK_W-1:0]  rd_req_block;
    logic [PAGE_W-1:0] rd_req_page;
    logic [CODE_W-1:0] rd_req_code;
    logic              rd_rsp_valid = 1'b0;
    logic [ERR_W-1:0]  rd_rsp_errs = '0;
    logic [BLK_W-1:0]  qry_block = '0;
    logic [CODE_W-1:0] qry_code;
    logic [PAGE_W-1:0] qry_page;

    vpass_tuner dut_i (
        .clk(clk), .rst_n(rst_n),
        .tune_start(tune_start), .tune_block(tune_block), .tune_page(tune_page),
        .tune_step(tune_step), .tune_busy(tune_busy), .tune_done(tune_done),
        .host_req_valid(host_req_valid), .host_req_ready(host_req_ready),
        .host_block(host_block), .host_page(host_page),
        .host_rsp_valid(host_rsp_valid), .host_rsp_errs(host_rsp_errs),
        .host_rsp_retried(host_rsp_retried),
        .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready),
        .rd_req_block(rd_req_block), .rd_req_page(rd_req_page),
        .rd_req_code(rd_req_code), .rd_rsp_valid(rd_rsp_valid),
        .rd_rsp_errs(rd_rsp_errs),
        .qry_block(qry_block), .qry_code(qry_code), .qry_page(qry_page)
    );

    int checks = 0;
    int errors = 0;

    // read-engine model: errors = base + 3 per LSB below the knee (+ host extra)
    int base_e [64];
    int knee_e [64];
    int host_extra = 0;
    int log_code [64];
    int log_page [64];
    int log_n = 0;
    int pend = 0;
    int pend_code = 0;
    int pend_blk = 0;
    int done_cnt = 0;
    int stall_cyc = 0;

    assign rd_req_ready = (stall_cyc % 3) != 1;

    always @(posedge clk) begin
        stall_cyc <= stall_cyc + 1;
        rd_rsp_valid <= 1'b0;
        if (tune_done) done_cnt <= done_cnt + 1;
        if (pend > 0) begin
            pend <= pend - 1;
            if (pend == 1) begin
                rd_rsp_valid <= 1'b1;
                rd_rsp_errs <= ERR_W'(base_e[pend_blk] + host_extra +
                    ((pend_code < knee_e[pend_blk]) ? 3 * (knee_e[pend_blk] - pend_code) : 0));
            end
        end else if (rd_req_valid && rd_req_ready) begin
            pend <= 2;
            pend_code <= int'(rd_req_code);
            pend_blk <= int'(rd_req_block);
            if (log_n < 64) begin
                log_code[log_n] <= int'(rd_req_code);
                log_page[log_n] <= int'(rd_req_page);
            end
            log_n <= log_n + 1;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic query(input int blk, output int code, output int page);
        @(negedge clk);
        qry_block = BLK_W'(blk);
        @(negedge clk);
        code = int'(qry_code);
        page = int'(qry_page);
    endtask

    task automatic run_tune(input int blk, input int page, input int step,
                            input int inject_blk);
        int guard = 0;
        @(negedge clk);
        log_n = 0;
        done_cnt = 0;
        tune_start = 1'b1;
        tune_block = BLK_W'(blk);
        tune_page = PAGE_W'(page);
        tune_step = CODE_W'(step);
        @(negedge clk);
        tune_start = 1'b0;
        check("R2 busy after trigger", int'(tune_busy), 1);
        if (inject_blk >= 0) begin
            repeat (3) @(negedge clk);
            tune_start = 1'b1;
            tune_block = BLK_W'(inject_blk);
            @(negedge clk);
            tune_start = 1'b0;
        end
        while (!tune_done && guard < 2000) begin
            @(negedge clk);
            guard++;
        end
        check("R2 busy low with done", int'(tune_busy), 0);
        @(negedge clk);
        check("R7 done is a single pulse", int'(tune_done), 0);
    endtask

    task automatic check_log(input string req, input int exp[], input int page);
        check(req, log_n, exp.size());
        for (int i = 0; i < exp.size() && i < log_n; i++) begin
            check(req, log_code[i], exp[i]);
        end
        if (log_n > 0) check("R3 first read on worst page", log_page[0], page);
    endtask

    task automatic test_reset();
        int c, p;
        check("R1 busy at reset", int'(tune_busy), 0);
        check("R1 no request at reset", int'(rd_req_valid), 0);
        query(0, c, p);
        check("R1 entry 0 code", c, 500);
        check("R1 entry 0 page", p, 0);
        query(63, c, p);
        check("R1 entry 63 code", c, 500);
    endtask

    task automatic test_coarse_fine();
        int c, p;
        base_e[3] = 10; knee_e[3] = 490;
        run_tune(3, 17, 8, -1);
        check_log("R4 R5 search sequence", '{500, 492, 484, 476, 477, 478, 479, 480}, 17);
        query(3, c, p);
        check("R5 fine result", c, 480);
        check("R7 stored page", p, 17);
    endtask

    task automatic test_floor();
        int c, p;
        base_e[7] = 0; knee_e[7] = 300;
        run_tune(7, 5, 8, -1);
        check_log("R6 floor clamp sequence", '{500, 492, 484, 476, 470}, 5);
        query(7, c, p);
        check("R6 result at floor", c, 470);
    endtask

    task automatic test_nominal_overflow();
        int c, p;
        base_e[9] = 45; knee_e[9] = 300;
        run_tune(9, 2, 8, -1);
        check_log("R3 single nominal read", '{500}, 2);
        query(9, c, p);
        check("R3 result nominal", c, 500);
        check("R7 page stored", p, 2);
    endtask

    task automatic test_big_step();
        int c, p;
        base_e[12] = 10; knee_e[12] = 480;
        run_tune(12, 9, 40, -1);
        check_log("R6 big step clamps", '{500, 470}, 9);
        query(12, c, p);
        check("R6 big step result", c, 470);
    endtask

    task automatic test_zero_step();
        int c, p;
        base_e[20] = 38; knee_e[20] = 499;
        run_tune(20, 1, 0, -1);
        check_log("R4 zero step as one", '{500, 499, 498, 499}, 1);
        query(20, c, p);
        check("R5 result after one step back", c, 499);
    endtask

    task automatic test_ignore_trigger();
        int c, p;
        base_e[30] = 0; knee_e[30] = 300;
        base_e[5] = 0; knee_e[5] = 300;
        run_tune(30, 4, 8, 5);
        check("R2 one done for one pass", done_cnt, 1);
        query(30, c, p);
        check("R2 tuned block result", c, 470);
        query(5, c, p);
        check("R2 ignored trigger left block 5", c, 500);
        check("R2 ignored trigger left page", p, 0);
    endtask

    task automatic host_read(input int blk, input int page, input int extra,
                             input int exp_errs, input int exp_retry,
                             input int exp_codes[]);
        int guard = 0;
        @(negedge clk);
        host_extra = extra;
        log_n = 0;
        host_req_valid = 1'b1;
        host_block = BLK_W'(blk);
        host_page = PAGE_W'(page);
        while (!host_req_ready && guard < 100) begin
            @(negedge clk);
            guard++;
        end
        @(negedge clk);
        host_req_valid = 1'b0;
        guard = 0;
        while (!host_rsp_valid && guard < 2000) begin
            @(negedge clk);
            guard++;
        end
        check("R8 R9 host errs", int'(host_rsp_errs), exp_errs);
        check("R8 R9 retried flag", int'(host_rsp_retried), exp_retry);
        check("R8 R9 request count", log_n, exp_codes.size());
        for (int i = 0; i < exp_codes.size() && i < log_n; i++) begin
            check("R8 host request code", log_code[i], exp_codes[i]);
        end
        if (log_n > 0) check("R8 host page", log_page[0], page);
        host_extra = 0;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 64; i++) begin
            base_e[i] = 0;
            knee_e[i] = 0;
        end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        test_coarse_fine();
        test_floor();
        test_nominal_overflow();
        test_big_step();
        test_zero_step();
        test_ignore_trigger();
        // R8: tuned code 480 gives exactly the capability, no retry
        host_read(3, 44, 0, 40, 0, '{480});
        // R8: overflow at tuned code, retried at nominal
        host_read(3, 45, 5, 15, 1, '{480, 500});
        // R9: block at nominal code overflows, not retried
        host_read(9, 6, 0, 45, 0, '{500});
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule